// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block sequences interrupt entry for a 32-bit embedded processor core. It handles three causes: an execute-permission fault on instruction fetch, an access-permission fault on a data access, and a level-sensitive external interrupt line. In any cycle where at least one cause is eligible, it picks a single winner. It then does the following in one clock:

- saves the faulting instruction address and the pre-entry machine state into two save/restore registers;
- produces the rewritten machine-state word;
- updates the syndrome register and the data fault address register as the winning cause requires;
- drives a one-cycle redirect to the fetch unit.

The redirect target is the upper 24 bits of a vector base input joined with an 8-bit offset that is fixed for each cause. The core is expected to adopt the new machine-state word when the write strobe fires. The core also retires the fault flags after entry. The external interrupt controller receives an acknowledge pulse when its request is the one taken.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, every output is 0: the save registers, the syndrome and fault address, the new machine-state word, redirect valid and address, the state write strobe, and the acknowledge.
- R2: When requests coincide, the instruction fault wins over the data fault, and the data fault wins over an eligible external interrupt.
- R3: The redirect address is vec_base_i[31:8] concatenated with an 8-bit offset. The offset is 0x30 for the instruction fault, 0x20 for the data fault and 0x40 for the external interrupt.
- R4: On entry, save0_o takes cur_pc_i and save1_o takes the full msr_i value from the request cycle.
- R5: On entry, msr_new_o equals msr_i with only bits 17, 12, 9 and 1 kept (critical enable, machine-check enable, debug enable, recoverable). Every other bit is 0, so bit 25, 18, 15, 14, 13, 11, 8, 5, 4 and 2 among them are cleared.
- R6: On an instruction-fault entry, syndrome_o takes fault_info_i masked to bits 8 (store), 7 (vector-unit) and 5 (variable-length encoding). All other bits are cleared, and fault_addr_o keeps its value.
- R7: On a data-fault entry, fault_addr_o takes data_addr_i and syndrome_o takes fault_info_i unmasked.
- R8: The external interrupt is taken only when ext_irq_i is high and msr_i bit 15 is 1. Its entry leaves syndrome_o and fault_addr_o unchanged and pulses ext_ack_o.
- R9: redir_vld_o and msr_wr_o are high in the cycle after a request cycle that yields an entry, and low after any other cycle. When no entry occurs, all saved registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ifetch_fault_i | input | 1 | Execute-permission fault on the current instruction |
| data_fault_i | input | 1 | Access-permission fault on a data access |
| ext_irq_i | input | 1 | Level-sensitive external interrupt request |
| cur_pc_i | input | 32 | Address of the excepting instruction |
| data_addr_i | input | 32 | Effective address of the faulting data access |
| fault_info_i | input | 32 | Syndrome indications from fetch or load/store |
| msr_i | input | 32 | Current machine-state word |
| vec_base_i | input | 32 | Vector base; bits 31:8 are used |
| save0_o | output | 32 | Saved return address |
| save1_o | output | 32 | Saved machine-state word |
| syndrome_o | output | 32 | Exception syndrome register |
| fault_addr_o | output | 32 | Data fault address register |
| msr_new_o | output | 32 | Rewritten machine-state word |
| msr_wr_o | output | 1 | One-cycle strobe to load msr_new_o |
| redir_vld_o | output | 1 | One-cycle redirect request to fetch |
| redir_addr_o | output | 32 | Vector fetch address |
| ext_ack_o | output | 1 | Acknowledge to the interrupt controller |

## Verification
The bench drives all three requests together and in pairs. A broken priority encoder would vector to the wrong offset or write the wrong syndrome. An external request with bit 15 of the state word low must produce no entry; a design that ignored the enable would redirect and acknowledge anyway. Back-to-back instruction faults must leave the data fault address untouched, and an external entry must leave both syndrome and fault address untouched; a design that wrote them unconditionally would lose the previous contents. The state-word check uses inputs with every bit set, so any wrongly kept or wrongly cleared bit shows at once.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN  = 32;
  localparam int OFF_W = 8;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_IFTCH = 2'd1,
    CAUSE_DATA  = 2'd2,
    CAUSE_EXT   = 2'd3
  } cause_e;

  // machine-state bit positions (LSB = 0)
  localparam int MS_CRIT  = 17;
  localparam int MS_EXTEN = 15;
  localparam int MS_MCHK  = 12;
  localparam int MS_DBG   = 9;
  localparam int MS_RECOV = 1;

  localparam logic [XLEN-1:0] MS_KEEP_MASK =
    (XLEN'(1) << MS_CRIT) | (XLEN'(1) << MS_MCHK) |
    (XLEN'(1) << MS_DBG)  | (XLEN'(1) << MS_RECOV);

  // syndrome bits that survive an instruction-fault entry
  localparam logic [XLEN-1:0] IF_SYN_MASK =
    (XLEN'(1) << 8) | (XLEN'(1) << 7) | (XLEN'(1) << 5);

  localparam logic [OFF_W-1:0] OFF_DATA  = 8'h20;
  localparam logic [OFF_W-1:0] OFF_IFTCH = 8'h30;
  localparam logic [OFF_W-1:0] OFF_EXT   = 8'h40;
endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
#(
  parameter int EN_BIT = MS_EXTEN
) (
  input  logic         ifetch_fault,
  input  logic         data_fault,
  input  logic         ext_irq,
  input  logic [XLEN-1:0] msr,
  output cause_e       cause
);
  logic ext_ok;

  always_comb begin
    ext_ok = ext_irq & msr[EN_BIT];
    if (ifetch_fault)    cause = CAUSE_IFTCH;
    else if (data_fault) cause = CAUSE_DATA;
    else if (ext_ok)     cause = CAUSE_EXT;
    else                 cause = CAUSE_NONE;
  end
endmodule

// File: rtl/exc_entry_calc.sv
module exc_entry_calc
  import exc_entry_pkg::*;
#(
  parameter logic [XLEN-1:0] KEEP_MASK = MS_KEEP_MASK,
  parameter logic [XLEN-1:0] SYN_MASK  = IF_SYN_MASK
) (
  input  cause_e          cause,
  input  logic [XLEN-1:0] msr,
  input  logic [XLEN-1:0] vec_base,
  input  logic [XLEN-1:0] fault_info,
  input  logic [XLEN-1:0] data_addr,
  input  logic [XLEN-1:0] syn_cur,
  input  logic [XLEN-1:0] dear_cur,
  output logic [XLEN-1:0] msr_nxt,
  output logic [XLEN-1:0] vec_nxt,
  output logic [XLEN-1:0] syn_nxt,
  output logic [XLEN-1:0] dear_nxt
);
  localparam int HI_W = XLEN - OFF_W;

  logic [OFF_W-1:0] off;

  always_comb begin
    msr_nxt  = msr & KEEP_MASK;
    syn_nxt  = syn_cur;
    dear_nxt = dear_cur;
    off      = OFF_EXT;
    unique case (cause)
      CAUSE_IFTCH: begin
        off     = OFF_IFTCH;
        syn_nxt = fault_info & SYN_MASK;
      end
      CAUSE_DATA: begin
        off      = OFF_DATA;
        syn_nxt  = fault_info;
        dear_nxt = data_addr;
      end
      default: off = OFF_EXT;
    endcase
    vec_nxt = {vec_base[XLEN-1 -: HI_W], off};
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ifetch_fault_i,
  input  logic        data_fault_i,
  input  logic        ext_irq_i,
  input  logic [31:0] cur_pc_i,
  input  logic [31:0] data_addr_i,
  input  logic [31:0] fault_info_i,
  input  logic [31:0] msr_i,
  input  logic [31:0] vec_base_i,
  output logic [31:0] save0_o,
  output logic [31:0] save1_o,
  output logic [31:0] syndrome_o,
  output logic [31:0] fault_addr_o,
  output logic [31:0] msr_new_o,
  output logic        msr_wr_o,
  output logic        redir_vld_o,
  output logic [31:0] redir_addr_o,
  output logic        ext_ack_o
);
  cause_e          cause;
  logic            take;
  logic [XLEN-1:0] msr_nxt, vec_nxt, syn_nxt, dear_nxt;

  exc_arbiter u_arb (
    .ifetch_fault (ifetch_fault_i),
    .data_fault   (data_fault_i),
    .ext_irq      (ext_irq_i),
    .msr          (msr_i),
    .cause        (cause)
  );

  exc_entry_calc u_calc (
    .cause      (cause),
    .msr        (msr_i),
    .vec_base   (vec_base_i),
    .fault_info (fault_info_i),
    .data_addr  (data_addr_i),
    .syn_cur    (syndrome_o),
    .dear_cur   (fault_addr_o),
    .msr_nxt    (msr_nxt),
    .vec_nxt    (vec_nxt),
    .syn_nxt    (syn_nxt),
    .dear_nxt   (dear_nxt)
  );

  assign take = (cause != CAUSE_NONE);

  // entry-state registers, loaded only on an entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save0_o      <= '0;
      save1_o      <= '0;
      syndrome_o   <= '0;
      fault_addr_o <= '0;
      msr_new_o    <= '0;
      redir_addr_o <= '0;
    end else if (take) begin
      save0_o      <= cur_pc_i;
      save1_o      <= msr_i;
      syndrome_o   <= syn_nxt;
      fault_addr_o <= dear_nxt;
      msr_new_o    <= msr_nxt;
      redir_addr_o <= vec_nxt;
    end
  end

  // single-cycle strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msr_wr_o    <= 1'b0;
      redir_vld_o <= 1'b0;
      ext_ack_o   <= 1'b0;
    end else begin
      msr_wr_o    <= take;
      redir_vld_o <= take;
      ext_ack_o   <= (cause == CAUSE_EXT);
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ifetch_fault_i,
  input logic        data_fault_i,
  input logic        ext_irq_i,
  input logic [31:0] msr_i,
  input logic [31:0] vec_base_i,
  input logic [31:0] save1_o,
  input logic [31:0] fault_addr_o,
  input logic [31:0] syndrome_o,
  input logic [31:0] msr_new_o,
  input logic        redir_vld_o,
  input logic [31:0] redir_addr_o,
  input logic        ext_ack_o
);
  // R2
  ifetch_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_fault_i |=> (redir_vld_o && redir_addr_o[7:0] == 8'h30 && !ext_ack_o));

  // R3
  vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_fault_i || data_fault_i) |=> (redir_addr_o[31:8] == $past(vec_base_i[31:8])));

  // R4
  save_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ifetch_fault_i || data_fault_i) |=> (save1_o == $past(msr_i)));

  // R5
  msr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_vld_o |-> ((msr_new_o & ~MS_KEEP_MASK) == '0));

  // R6
  ifetch_dear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ifetch_fault_i |=> $stable(fault_addr_o));

  // R8
  ext_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_irq_i && !msr_i[MS_EXTEN] && !ifetch_fault_i && !data_fault_i) |=>
      (!redir_vld_o && $stable(syndrome_o)));

  // R8
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack_o |-> (redir_vld_o && redir_addr_o[7:0] == 8'h40));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .ifetch_fault_i (ifetch_fault_i),
  .data_fault_i   (data_fault_i),
  .ext_irq_i      (ext_irq_i),
  .msr_i          (msr_i),
  .vec_base_i     (vec_base_i),
  .save1_o        (save1_o),
  .fault_addr_o   (fault_addr_o),
  .syndrome_o     (syndrome_o),
  .msr_new_o      (msr_new_o),
  .redir_vld_o    (redir_vld_o),
  .redir_addr_o   (redir_addr_o),
  .ext_ack_o      (ext_ack_o)
);

// File: tb/exc_entry_ctrl_tb.sv
module exc_entry_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic ifetch_fault_i, data_fault_i, ext_irq_i;
  logic [31:0] cur_pc_i, data_addr_i, fault_info_i, msr_i, vec_base_i;
  logic [31:0] save0_o, save1_o, syndrome_o, fault_addr_o, msr_new_o, redir_addr_o;
  logic msr_wr_o, redir_vld_o, ext_ack_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  logic [31:0] m_s0, m_s1, m_syn, m_dear, m_msr, m_vec;
  logic m_vld, m_ack;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_ctrl u_dut (.*);

  function automatic logic [31:0] keep_bits(input logic [31:0] m);
    return m & ((32'h1 << 17) | (32'h1 << 12) | (32'h1 << 9) | (32'h1 << 1));
  endfunction

  // 0 none, 1 ifetch, 2 data, 3 ext
  function automatic int pick(input logic i, input logic d, input logic e, input logic [31:0] m);
    if (i) return 1;
    if (d) return 2;
    if (e && m[15]) return 3;
    return 0;
  endfunction

  task automatic cmp(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic i, input logic d, input logic e, input logic [31:0] pc,
                       input logic [31:0] da, input logic [31:0] fi, input logic [31:0] m,
                       input logic [31:0] vb);
    int c;
    ifetch_fault_i = i; data_fault_i = d; ext_irq_i = e;
    cur_pc_i = pc; data_addr_i = da; fault_info_i = fi; msr_i = m; vec_base_i = vb;
    c = pick(i, d, e, m);
    m_vld = (c != 0);
    m_ack = (c == 3);
    if (c != 0) begin
      m_s0  = pc;
      m_s1  = m;
      m_msr = keep_bits(m);
      m_vec = {vb[31:8], (c == 1) ? 8'h30 : (c == 2) ? 8'h20 : 8'h40};
      if (c == 1) m_syn = fi & 32'h0000_01A0;
      if (c == 2) begin m_syn = fi; m_dear = da; end
    end
    @(negedge clk);
    cmp("R9", "redir_vld", {31'b0, redir_vld_o}, {31'b0, m_vld});
    cmp("R9", "msr_wr", {31'b0, msr_wr_o}, {31'b0, m_vld});
    cmp("R8", "ext_ack", {31'b0, ext_ack_o}, {31'b0, m_ack});
    cmp("R2/R3", "redir_addr", redir_addr_o, m_vec);
    cmp("R4", "save0", save0_o, m_s0);
    cmp("R4", "save1", save1_o, m_s1);
    cmp("R5", "msr_new", msr_new_o, m_msr);
    cmp("R6/R7", "syndrome", syndrome_o, m_syn);
    cmp("R6/R7", "fault_addr", fault_addr_o, m_dear);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    ifetch_fault_i = 0; data_fault_i = 0; ext_irq_i = 0;
    cur_pc_i = 0; data_addr_i = 0; fault_info_i = 0; msr_i = 0; vec_base_i = 0;
    m_s0 = 0; m_s1 = 0; m_syn = 0; m_dear = 0; m_msr = 0; m_vec = 0; m_vld = 0; m_ack = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    cmp("R1", "save0", save0_o, 0);
    cmp("R1", "save1", save1_o, 0);
    cmp("R1", "syndrome", syndrome_o, 0);
    cmp("R1", "fault_addr", fault_addr_o, 0);
    cmp("R1", "msr_new", msr_new_o, 0);
    cmp("R1", "redir_addr", redir_addr_o, 0);
    cmp("R1", "strobes", {29'b0, redir_vld_o, msr_wr_o, ext_ack_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    // R2: all three at once, instruction fault wins
    apply(1, 1, 1, 32'h1000_0004, 32'hAAAA_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h8765_43FF);
    // R2: data beats external; R7 dear loaded
    apply(0, 1, 1, 32'h1000_0008, 32'hBBBB_0010, 32'h1234_5678, 32'hFFFF_FFFF, 32'h1122_3344);
    // R6: instruction fault leaves dear alone
    apply(1, 0, 0, 32'h1000_000C, 32'hCCCC_0020, 32'h0000_0FFF, 32'h0002_1202, 32'h0);
    // R8: external masked by bit 15 low
    apply(0, 0, 1, 32'h1000_0010, 32'hDDDD_0030, 32'hFFFF_0000, 32'hFFFF_7FFF, 32'hFFFF_FFFF);
    // R8: external enabled, syndrome and dear unchanged
    apply(0, 0, 1, 32'h1000_0014, 32'hEEEE_0040, 32'hFFFF_0000, 32'h0000_8000, 32'hABCD_EF00);
    // R9: idle cycle, registers hold
    apply(0, 0, 0, 32'h1000_0018, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0);
    // R9: back-to-back entries
    apply(0, 1, 0, 32'h2000_0000, 32'h3000_0000, 32'h0000_0100, 32'h0, 32'h4000_0000);
    apply(0, 1, 0, 32'h2000_0004, 32'h3000_0004, 32'h0000_0200, 32'h0, 32'h4000_0000);

    // constrained random
    for (int k = 0; k < 600; k++) begin
      logic i, d, e;
      i = ($urandom % 5) == 0;
      d = ($urandom % 4) == 0;
      e = ($urandom % 2) == 0;
      apply(i, d, e, $urandom, $urandom, $urandom, $urandom, $urandom);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule